// File: doc/BRIEF.md
# Coprocessor-0 Exception and Interrupt Unit

This block holds the system-control state that a classic 32-bit MIPS-style core needs to enter and leave exceptions: a status register with a three-deep kernel/interrupt-enable stack, a cause register, an exception return address, a fixed processor identifier, and a pair of interrupt status and mask registers. The pipeline presents an exception request with a 5-bit code, a 2-bit branch-delay field and the current program counter. On the next clock edge the unit records the trap, pushes the mode stack and issues a one-cycle redirect strobe with the handler address.

Hardware interrupt lines set bits in the interrupt status register. Software clears them by acknowledging, and enables them through the mask register. Whenever a set bit is also enabled, the summary bit in the cause register rises. If the status register allows it, the unit then raises an interrupt exception on its own. A return-from-exception strobe pops the mode stack. A small write port lets software load the status register, the two software-interrupt bits of the cause register, the mask register and the acknowledge register.

Top module: `cp0_exc_unit`

## Requirements
- R1: After reset the redirect address is 0xBFC00000, status is 0x10600000, the identifier reads 0x00000002, the strobe is low, and cause, return address, interrupt status and mask are all zero.
- R2: On a taken exception, cause becomes {branch-delay field in bits 31:30, zeros in 29:11, interrupt summary in bit 10, old bits 9:8, 0 in bit 7, exception code in bits 6:2, zeros in 1:0}.
- R3: On a taken exception, the return address is the current PC minus 4 when the branch-delay field is nonzero, and the current PC otherwise.
- R4: The redirect address is 0xBFC00180 when status bit 22 was set before the exception, and 0x80000080 when it was clear.
- R5: On a taken exception, status bits 5:0 become {old bits 3:0, 2'b00}, and bits 31:6 are unchanged.
- R6: A return-from-exception strobe without an exception loads status bits 3:0 from bits 5:2 and leaves bits 31:4 unchanged.
- R7: Cause bit 10 equals the OR of (interrupt status AND mask) as held one cycle earlier.
- R8: When status bit 0, status bit 10 and cause bit 10 are all set and no request is present, the unit takes an exception with code 0 on the next edge.
- R9: Write-select 2 clears interrupt-status bits where the data bit is 0. A hardware line sets its bit, and a set wins over a clear in the same cycle. Write-select 3 loads the mask, write-select 1 loads status, and write-select 4 loads cause bits 9:8 from data bits 9:8.
- R10: The strobe is high for exactly the cycle after each taken exception. A request in the same cycle as a pending interrupt is taken with the requested code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| exc_req | input | 1 | Exception request from the pipeline |
| exc_code | input | 5 | Exception code of the request |
| exc_bd | input | 2 | Branch-delay field; nonzero means the faulting instruction is in a delay slot |
| cur_pc | input | 32 | PC of the faulting instruction |
| rfe | input | 1 | Return-from-exception strobe |
| hw_irq | input | IRQ_W | Hardware interrupt lines (level, sets status bits) |
| wr_sel | input | 3 | Write target: 0 none, 1 status, 2 acknowledge, 3 mask, 4 cause software bits |
| wr_data | input | 32 | Write data |
| take_o | output | 1 | Redirect strobe |
| redirect_pc_o | output | 32 | Redirect / handler address |
| sr_o | output | 32 | Status register |
| cause_o | output | 32 | Cause register |
| epc_o | output | 32 | Exception return address |
| prid_o | output | 32 | Processor identifier |
| istat_o | output | IRQ_W | Interrupt status register |
| imask_o | output | IRQ_W | Interrupt mask register |

## Verification
A request, a return strobe or a register write shows up on the outputs one edge after it is applied. An interrupt takes longer. A hardware line reaches the interrupt status register one edge later, the cause summary bit follows one edge after that, and the interrupt exception appears on the edge after the summary bit and the status enables are all set. The bench drives inputs just after a rising edge and reads the outputs just after the next one. It steps through this pipeline one edge at a time and checks each stage in the cycle it is due. It also checks that the strobe has fallen one edge later.

// File: rtl/cp0_pkg.sv
// Package: shared constants and write-select encoding for the coprocessor-0
// exception unit. Assumes a 32-bit address space.
package cp0_pkg;
    localparam int XLEN      = 32;
    localparam int CODE_W    = 5;
    localparam int BD_W      = 2;
    localparam int SEL_W     = 3;
    localparam int SR_BOOT_B = 22;   // boot-vector select bit
    localparam int SR_IMSK_B = 10;   // status enable bit for the summary interrupt
    localparam int CA_SUM_B  = 10;   // cause summary interrupt bit
    localparam int PAD_W     = XLEN - BD_W - 11;  // zero run in cause 29:11

    localparam logic [XLEN-1:0] RESET_PC = 32'hBFC0_0000;
    localparam logic [XLEN-1:0] RESET_SR = 32'h1060_0000;
    localparam logic [XLEN-1:0] PRID_VAL = 32'h0000_0002;
    localparam logic [XLEN-1:0] VEC_BOOT = 32'hBFC0_0180;
    localparam logic [XLEN-1:0] VEC_RAM  = 32'h8000_0080;
    localparam logic [XLEN-1:0] SLOT_SZ  = 32'd4;

    typedef enum logic [SEL_W-1:0] {
        CW_NONE   = 3'd0,
        CW_STATUS = 3'd1,
        CW_IACK   = 3'd2,
        CW_IMASK  = 3'd3,
        CW_SOFT   = 3'd4
    } cw_sel_e;
endpackage

// File: rtl/cp0_irq_regs.sv
// Module: interrupt status and mask pair. Hardware lines set status bits,
// an acknowledge write clears bits whose data bit is 0 (set wins), the mask
// is a plain register. Produces the OR-reduced pending summary.
module cp0_irq_regs #(
    parameter int IRQ_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] hw_irq,
    input  logic             ack_we,
    input  logic             mask_we,
    input  logic [IRQ_W-1:0] wdata,
    output logic [IRQ_W-1:0] istat_o,
    output logic [IRQ_W-1:0] imask_o,
    output logic             pend_o
);
    logic [IRQ_W-1:0] keep;

    // Acknowledge keeps only bits written as 1.
    always_comb keep = ack_we ? wdata : '1;

    // Status bits: clear on acknowledge, then OR in hardware lines.
    always_ff @(posedge clk) begin
        if (!rst_n) istat_o <= '0;
        else        istat_o <= (istat_o & keep) | hw_irq;
    end

    // Mask register: plain load.
    always_ff @(posedge clk) begin
        if (!rst_n)       imask_o <= '0;
        else if (mask_we) imask_o <= wdata;
    end

    // Pending summary from the held registers.
    always_comb pend_o = |(istat_o & imask_o);
endmodule

// File: rtl/cp0_status_reg.sv
// Module: status register with the 3-deep mode/interrupt-enable stack.
// Exception pushes (shift left by two), return pops (shift right by two
// into bits 3:0). Priority: exception, return, software write.
module cp0_status_reg
    import cp0_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic            rfe,
    input  logic            sr_we,
    input  logic [XLEN-1:0] sr_wdata,
    output logic [XLEN-1:0] sr_o
);
    // Status update with push/pop of the low six bits.
    always_ff @(posedge clk) begin
        if (!rst_n)     sr_o <= RESET_SR;
        else if (take)  sr_o <= {sr_o[XLEN-1:6], sr_o[3:0], 2'b00};
        else if (rfe)   sr_o <= {sr_o[XLEN-1:4], sr_o[5:2]};
        else if (sr_we) sr_o <= sr_wdata;
    end
endmodule

// File: rtl/cp0_trap_regs.sv
// Module: cause, return address, redirect address and strobe. Assumes the
// caller has already resolved which code is taken this cycle.
module cp0_trap_regs
    import cp0_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [CODE_W-1:0] code,
    input  logic [BD_W-1:0]   bd,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic              boot_vec,
    input  logic              pend,
    input  logic              soft_we,
    input  logic [1:0]        soft_wdata,
    output logic [XLEN-1:0]   cause_o,
    output logic [XLEN-1:0]   epc_o,
    output logic [XLEN-1:0]   redirect_o,
    output logic              strobe_o
);
    logic [XLEN-1:0] ret_addr;

    // Return address backs up one slot for delay-slot faults.
    always_comb ret_addr = (bd != '0) ? (cur_pc - SLOT_SZ) : cur_pc;

    // Cause: summary bit every cycle, full rebuild on exception.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_o <= '0;
        end else if (take) begin
            cause_o <= {bd, {PAD_W{1'b0}}, pend, cause_o[9:8], 1'b0, code, 2'b00};
        end else begin
            cause_o[CA_SUM_B] <= pend;
            if (soft_we) cause_o[9:8] <= soft_wdata;
        end
    end

    // Return address, redirect target and one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_o      <= '0;
            redirect_o <= RESET_PC;
            strobe_o   <= 1'b0;
        end else begin
            strobe_o <= take;
            if (take) begin
                epc_o      <= ret_addr;
                redirect_o <= boot_vec ? VEC_BOOT : VEC_RAM;
            end
        end
    end
endmodule

// File: rtl/cp0_exc_unit.sv
// Module: top of the coprocessor-0 exception unit. Arbitrates a pipeline
// request against the internal interrupt condition (request wins) and
// decodes the software write port. Assumes one request per cycle at most.
module cp0_exc_unit
    import cp0_pkg::*;
#(
    parameter int IRQ_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_req,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [BD_W-1:0]   exc_bd,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic              rfe,
    input  logic [IRQ_W-1:0]  hw_irq,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [XLEN-1:0]   wr_data,
    output logic              take_o,
    output logic [XLEN-1:0]   redirect_pc_o,
    output logic [XLEN-1:0]   sr_o,
    output logic [XLEN-1:0]   cause_o,
    output logic [XLEN-1:0]   epc_o,
    output logic [XLEN-1:0]   prid_o,
    output logic [IRQ_W-1:0]  istat_o,
    output logic [IRQ_W-1:0]  imask_o
);
    cw_sel_e           sel;
    logic              take_int, take;
    logic [CODE_W-1:0] code;
    logic              pend;

    // Write-port decode.
    always_comb sel = cw_sel_e'(wr_sel);

    // Interrupt condition and arbitration; request has priority.
    always_comb begin
        take_int = sr_o[0] & sr_o[SR_IMSK_B] & cause_o[CA_SUM_B];
        take     = exc_req | take_int;
        code     = exc_req ? exc_code : '0;
    end

    assign prid_o = PRID_VAL;

    cp0_irq_regs #(.IRQ_W(IRQ_W)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_irq  (hw_irq),
        .ack_we  (sel == CW_IACK),
        .mask_we (sel == CW_IMASK),
        .wdata   (wr_data[IRQ_W-1:0]),
        .istat_o (istat_o),
        .imask_o (imask_o),
        .pend_o  (pend)
    );

    cp0_status_reg u_sr (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .rfe      (rfe),
        .sr_we    (sel == CW_STATUS),
        .sr_wdata (wr_data),
        .sr_o     (sr_o)
    );

    cp0_trap_regs u_trap (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .code       (code),
        .bd         (exc_bd),
        .cur_pc     (cur_pc),
        .boot_vec   (sr_o[SR_BOOT_B]),
        .pend       (pend),
        .soft_we    (sel == CW_SOFT),
        .soft_wdata (wr_data[9:8]),
        .cause_o    (cause_o),
        .epc_o      (epc_o),
        .redirect_o (redirect_pc_o),
        .strobe_o   (take_o)
    );
endmodule

// File: rtl/cp0_exc_chk.sv
// Module: property checker for cp0_exc_unit, attached through bind.
module cp0_exc_chk
    import cp0_pkg::*;
#(
    parameter int IRQ_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exc_req,
    input logic [BD_W-1:0]   exc_bd,
    input logic [XLEN-1:0]   cur_pc,
    input logic              take_o,
    input logic [XLEN-1:0]   redirect_pc_o,
    input logic [XLEN-1:0]   sr_o,
    input logic [XLEN-1:0]   cause_o,
    input logic [XLEN-1:0]   epc_o,
    input logic [IRQ_W-1:0]  istat_o,
    input logic [IRQ_W-1:0]  imask_o
);
    // R10
    req_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(exc_req) |-> take_o);

    // R5
    sr_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (sr_o[1:0] == 2'b00) && (sr_o[5:2] == $past(sr_o[3:0])));

    // R3
    epc_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && $past(exc_bd) == '0) |-> epc_o == $past(cur_pc));

    // R4
    vec_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> redirect_pc_o == ($past(sr_o[SR_BOOT_B]) ? VEC_BOOT : VEC_RAM));

    // R7
    irq_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cause_o[CA_SUM_B] == $past(|(istat_o & imask_o)));

    // R8
    int_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !$past(exc_req)) |-> cause_o[6:2] == '0);
endmodule

bind cp0_exc_unit cp0_exc_chk #(.IRQ_W(IRQ_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .exc_req       (exc_req),
    .exc_bd        (exc_bd),
    .cur_pc        (cur_pc),
    .take_o        (take_o),
    .redirect_pc_o (redirect_pc_o),
    .sr_o          (sr_o),
    .cause_o       (cause_o),
    .epc_o         (epc_o),
    .istat_o       (istat_o),
    .imask_o       (imask_o)
);

// File: tb/sim_cp0_exc_unit.sv
module sim_cp0_exc_unit;
    localparam int IRQ_W = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 1'b0;
    logic [4:0]  exc_code = '0;
    logic [1:0]  exc_bd = '0;
    logic [31:0] cur_pc = '0;
    logic        rfe = 1'b0;
    logic [31:0] hw_irq = '0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        take_o;
    logic [31:0] redirect_pc_o, sr_o, cause_o, epc_o, prid_o;
    logic [31:0] istat_o, imask_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    cp0_exc_unit #(.IRQ_W(IRQ_W)) u0 (.*);

    typedef struct packed {
        logic [31:0] sr_in;
        logic [1:0]  bd;
        logic [4:0]  code;
        logic [31:0] pc;
        logic [31:0] vec;
        logic [31:0] epc;
        logic [31:0] sr_out;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{sr_in:32'h1060_0000, bd:2'd2, code:5'd4,  pc:32'h8000_1000,
          vec:32'hBFC0_0180, epc:32'h8000_0FFC, sr_out:32'h1060_0000},
        '{sr_in:32'h0000_003F, bd:2'd0, code:5'd8,  pc:32'h0040_0020,
          vec:32'h8000_0080, epc:32'h0040_0020, sr_out:32'h0000_003C},
        '{sr_in:32'h1040_0005, bd:2'd1, code:5'd10, pc:32'h0000_0004,
          vec:32'hBFC0_0180, epc:32'h0000_0000, sr_out:32'h1040_0014},
        '{sr_in:32'h0000_0029, bd:2'd3, code:5'd31, pc:32'h1234_5678,
          vec:32'h8000_0080, epc:32'h1234_5674, sr_out:32'h0000_0024}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // One clock edge; inputs change and outputs are read 1 ns after it.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        exc_req = 1'b0; rfe = 1'b0; hw_irq = '0; wr_sel = '0; wr_data = '0;
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 pc", redirect_pc_o, 32'hBFC0_0000);
        chk("R1 sr", sr_o, 32'h1060_0000);
        chk("R1 prid", prid_o, 32'h0000_0002);
        chk("R1 take", {31'd0, take_o}, 32'd0);
        chk("R1 cause", cause_o, 32'd0);
        chk("R1 epc", epc_o, 32'd0);
        chk("R1 istat", istat_o, 32'd0);
        chk("R1 imask", imask_o, 32'd0);

        // R9 software bits of cause (select 4)
        wr_sel = 3'd4; wr_data = 32'h0000_0200;
        step(); idle();
        chk("R9 soft bits", cause_o, 32'h0000_0200);

        // R2..R5 table of exceptions
        for (int i = 0; i < 4; i++) begin
            wr_sel = 3'd1; wr_data = VECS[i].sr_in;
            step(); idle();
            chk("R9 sr write", sr_o, VECS[i].sr_in);
            exc_req = 1'b1; exc_code = VECS[i].code; exc_bd = VECS[i].bd;
            cur_pc = VECS[i].pc;
            step(); idle();
            chk("R10 take", {31'd0, take_o}, 32'd1);
            chk("R4 vector", redirect_pc_o, VECS[i].vec);
            chk("R3 epc", epc_o, VECS[i].epc);
            chk("R5 sr push", sr_o, VECS[i].sr_out);
            chk("R2 cause", cause_o,
                {VECS[i].bd, 19'd0, 1'b0, 2'b10, 1'b0, VECS[i].code, 2'b00});
            step();
            chk("R10 pulse", {31'd0, take_o}, 32'd0);
        end

        // R6 return pops: 0x24 -> 0x29
        rfe = 1'b1;
        step(); idle();
        chk("R6 pop", sr_o, 32'h0000_0029);

        // R9 hardware set, R7 summary stays low while masked
        exc_bd = '0; cur_pc = 32'h0040_1000;
        hw_irq = 32'h10;
        step(); idle();
        chk("R9 hw set", istat_o, 32'h10);
        step();
        chk("R7 masked", {31'd0, cause_o[10]}, 32'd0);

        wr_sel = 3'd3; wr_data = 32'h10;
        step(); idle();
        chk("R9 mask", imask_o, 32'h10);
        step();
        chk("R7 summary", {31'd0, cause_o[10]}, 32'd1);
        chk("R8 not enabled", {31'd0, take_o}, 32'd0);

        // R8 enable bits 0 and 10
        wr_sel = 3'd1; wr_data = 32'h0000_0401;
        step(); idle();
        step();
        chk("R8 take", {31'd0, take_o}, 32'd1);
        chk("R8 cause", cause_o, 32'h0000_0600);
        chk("R8 vector", redirect_pc_o, 32'h8000_0080);
        chk("R8 epc", epc_o, 32'h0040_1000);
        chk("R8 sr", sr_o, 32'h0000_0404);
        step();
        chk("R10 int pulse", {31'd0, take_o}, 32'd0);

        // R9 acknowledge clears, R7 summary falls
        wr_sel = 3'd2; wr_data = ~32'h10;
        step(); idle();
        chk("R9 ack", istat_o, 32'd0);
        step();
        chk("R7 fall", {31'd0, cause_o[10]}, 32'd0);

        // R9 set wins over clear
        hw_irq = 32'h10; wr_sel = 3'd2; wr_data = 32'd0;
        step(); idle();
        chk("R9 set wins", istat_o, 32'h10);
        step();
        chk("R7 rise", {31'd0, cause_o[10]}, 32'd1);

        // R10 request beats pending interrupt
        wr_sel = 3'd1; wr_data = 32'h0000_0401;
        step(); idle();
        exc_req = 1'b1; exc_code = 5'd12; exc_bd = '0; cur_pc = 32'h0000_2000;
        step(); idle();
        chk("R10 prio take", {31'd0, take_o}, 32'd1);
        chk("R10 prio cause", cause_o, 32'h0000_0630);
        chk("R10 prio epc", epc_o, 32'h0000_2000);
        step();
        chk("R10 prio pulse", {31'd0, take_o}, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule